// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind a serial memory protocol decoder. It collects the data bytes of one write transaction in a 16-slot page latch and later copies them into a 1024 x 8 storage array. The decoder loads a start address, then strobes in data bytes one at a time. Each byte lands in the slot named by the low four bits of a shared address pointer. Only those low bits advance, so a long burst wraps inside its page and newer bytes replace older ones.

The array is untouched while bytes are collected. When the decoder reports the end of the transaction (a STOP or a repeated START), the buffered bytes are committed. The commit runs as a self-timed window whose length is a parameter in system clocks, and `busy` is high for the whole window. Only the slots filled in this transaction are written. A write-protect input discards the commit but leaves reads alone. A synchronous read port gives the array contents, and the pointer is visible so the decoder can serve current-address reads.

Top module: `page_commit_ctrl`

## Requirements
- R1: Up to 16 data bytes are held per transaction. A byte accepted while the pointer is at address A is stored for page location A.
- R2: Each accepted byte advances the low four pointer bits by one modulo 16. The upper pointer bits do not change, and `cur_addr` shows the pointer.
- R3: When more than 16 bytes arrive before the end of the transaction, a later byte for a slot replaces the earlier one. The final page contents are those of the newest byte per slot.
- R4: The array does not change before `txn_end`. A `txn_end` with at least one buffered byte and `wp` low raises `busy` on the next cycle. `busy` then stays high for exactly `WR_CYCLES` cycles; the default 1,000,000 is 10 ms at 100 MHz.
- R5: A commit writes only the slots loaded in that transaction. The other 15 or fewer bytes of the page keep their previous contents.
- R6: With `wp` high at `txn_end`, the buffer is discarded, `busy` stays low and no array location changes.
- R7: A `txn_end` with no byte buffered starts no commit, and `busy` stays low.
- R8: While `busy` is high, `byte_load`, `addr_load` and `txn_end` are ignored, and the pointer does not move.
- R9: After a commit the buffer is empty, so a following `txn_end` with no new bytes starts nothing. The pointer is left at the last loaded address plus one, wrapped within the page.
- R10: `rd_data` returns the array byte at the `rd_addr` sampled on the previous clock edge, whatever the value of `wp`.
- R11: `addr_load` is ignored while any byte is buffered. The page of the transaction is fixed by the address loaded before its first byte.
- R12: After reset, `busy` is 0 and `cur_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Load `addr_in` into the address pointer |
| addr_in | input | ADDR_W | Start address of a transaction |
| byte_load | input | 1 | Strobe: `byte_in` is a data byte to buffer |
| byte_in | input | 8 | Data byte |
| txn_end | input | 1 | One-cycle pulse at STOP or repeated START |
| wp | input | 1 | Write protect; high blocks every commit |
| busy | output | 1 | High during the self-timed write window |
| cur_addr | output | ADDR_W | Current address pointer |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array data, one cycle after `rd_addr` |

## Verification
The array can only be seen through the read port. A wrong slot index, a lost valid bit or a wrong page base therefore shows up as a wrong byte when the page is read back after `busy` falls. A stale valid bit shows up as an unexpected `busy` window after an empty `txn_end`. Pointer errors appear on `cur_addr` in the cycle after the offending byte strobe. Window-length errors appear as a `busy` count different from `WR_CYCLES`. The bench first fills the whole array with an arithmetic pattern through full-page bursts and sweeps every address. It then replays partial, wrapping, overflowing, protected and busy-time transactions against a model computed from the address arithmetic.

// File: rtl/eeprom_page_pkg.sv
package eeprom_page_pkg;

    parameter int DATA_W = 8;
    parameter int PAGE_W = 4;
    localparam int PAGE_SLOTS = 1 << PAGE_W;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [PAGE_W-1:0] slot_idx_t;

    // One page latch entry: content plus "loaded in this transaction" flag.
    typedef struct packed {
        logic  valid;
        byte_t data;
    } slot_t;

    // Write request into the page latch.
    typedef struct packed {
        logic      en;
        slot_idx_t idx;
        byte_t     data;
    } slot_wr_t;

    // Commit window phases: copy slots first, then pad to the full window.
    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_PROGRAM = 2'd1,
        SEQ_SETTLE  = 2'd2
    } seq_state_e;

    function automatic slot_idx_t slot_next(input slot_idx_t s);
        return s + 1'b1;
    endfunction

endpackage

// File: rtl/addr_pointer.sv
module addr_pointer
    import eeprom_page_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step_en,
    output logic [ADDR_W-1:0] ptr
);

    localparam int UP_W = ADDR_W - PAGE_W;

    logic [UP_W-1:0] page_q;
    slot_idx_t       slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            slot_q <= '0;
        end else if (load_en) begin
            page_q <= load_addr[ADDR_W-1:PAGE_W];
            slot_q <= load_addr[PAGE_W-1:0];
        end else if (step_en) begin
            slot_q <= slot_next(slot_q);
        end
    end

    assign ptr = {page_q, slot_q};

    // R2: stepping never leaves the page
    p_page_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        (step_en && !load_en) |=> (page_q == $past(page_q)));

    // R2: low bits advance modulo the page size
    p_slot_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (step_en && !load_en) |=> (slot_q == slot_idx_t'($past(slot_q) + 1'b1)));

endmodule

// File: rtl/page_latch.sv
module page_latch
    import eeprom_page_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  slot_wr_t                   wr,
    input  logic                       clear,
    output slot_t [PAGE_SLOTS-1:0]     slots,
    output logic                       any_valid
);

    slot_t [PAGE_SLOTS-1:0] slots_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
        end else begin
            for (int i = 0; i < PAGE_SLOTS; i++) begin
                if (clear) begin
                    slots_q[i].valid <= 1'b0;
                end else if (wr.en && (wr.idx == slot_idx_t'(i))) begin
                    slots_q[i].valid <= 1'b1;
                    slots_q[i].data  <= wr.data;
                end
            end
        end
    end

    always_comb begin
        any_valid = 1'b0;
        for (int i = 0; i < PAGE_SLOTS; i++) begin
            any_valid = any_valid | slots_q[i].valid;
        end
    end

    assign slots = slots_q;

    // R1: an accepted byte is held in its slot on the next cycle
    p_load_held_r1: assert property (@(posedge clk) disable iff (rst)
        (wr.en && !clear) |=> any_valid);

    // R9: a clear empties the whole latch
    p_clear_empty_r9: assert property (@(posedge clk) disable iff (rst)
        clear |=> !any_valid);

endmodule

// File: rtl/commit_sequencer.sv
module commit_sequencer
    import eeprom_page_pkg::*;
#(
    parameter int WR_CYCLES = 1000000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  slot_t [PAGE_SLOTS-1:0] slots,
    output logic                   busy,
    output logic                   done,
    output logic                   wr_en,
    output slot_idx_t              wr_idx,
    output byte_t                  wr_data
);

    localparam int HOLD  = (WR_CYCLES < PAGE_SLOTS) ? PAGE_SLOTS : WR_CYCLES;
    localparam int CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] LAST      = CNT_W'(HOLD - 1);
    localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(PAGE_SLOTS - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            SEQ_IDLE:    if (start) state_d = SEQ_PROGRAM;
            SEQ_PROGRAM: begin
                if (cnt_q == LAST)           state_d = SEQ_IDLE;
                else if (cnt_q == SLOT_LAST) state_d = SEQ_SETTLE;
            end
            SEQ_SETTLE:  if (cnt_q == LAST) state_d = SEQ_IDLE;
            default:     state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SEQ_IDLE) cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
        end
    end

    assign busy    = (state_q != SEQ_IDLE);
    assign done    = busy && (cnt_q == LAST);
    assign wr_idx  = cnt_q[PAGE_W-1:0];
    assign wr_data = slots[wr_idx].data;
    assign wr_en   = (state_q == SEQ_PROGRAM) && slots[wr_idx].valid;

    // R4: the window counter never passes the programmed length
    p_window_bound_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt_q <= LAST));

    // R4: every window begins with slot 0 of the copy phase
    p_window_entry_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ((state_q == SEQ_PROGRAM) && (cnt_q == '0)));

endmodule

// File: rtl/storage_array.sv
module storage_array
    import eeprom_page_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  byte_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output byte_t             rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
    import eeprom_page_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int WR_CYCLES = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_load,
    input  logic [7:0]        byte_in,
    input  logic              txn_end,
    input  logic              wp,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic                   any_valid;
    logic                   take_byte, take_addr, take_end;
    logic                   start_commit, discard;
    logic                   seq_done, seq_we;
    slot_idx_t              seq_idx;
    byte_t                  seq_data;
    slot_t [PAGE_SLOTS-1:0] slots;
    slot_wr_t               latch_wr;
    logic                   arr_we;
    logic [ADDR_W-1:0]      arr_waddr;

    // Edge gating: nothing enters while the window runs.
    assign take_byte    = byte_load && !busy;
    assign take_addr    = addr_load && !busy && !any_valid;
    assign take_end     = txn_end && !busy;
    assign start_commit = take_end && any_valid && !wp;
    assign discard      = take_end && any_valid && wp;

    assign latch_wr.en   = take_byte;
    assign latch_wr.idx  = cur_addr[PAGE_W-1:0];
    assign latch_wr.data = byte_in;

    addr_pointer #(.ADDR_W(ADDR_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load_en   (take_addr),
        .load_addr (addr_in),
        .step_en   (take_byte),
        .ptr       (cur_addr)
    );

    page_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .wr        (latch_wr),
        .clear     (seq_done || discard),
        .slots     (slots),
        .any_valid (any_valid)
    );

    commit_sequencer #(.WR_CYCLES(WR_CYCLES)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start_commit),
        .slots   (slots),
        .busy    (busy),
        .done    (seq_done),
        .wr_en   (seq_we),
        .wr_idx  (seq_idx),
        .wr_data (seq_data)
    );

    // Page base comes from the frozen upper pointer bits.
    assign arr_we    = seq_we && !wp;
    assign arr_waddr = {cur_addr[ADDR_W-1:PAGE_W], seq_idx};

    storage_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (seq_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // R4: a non-empty end of transaction opens the window
    p_commit_start_r4: assert property (@(posedge clk) disable iff (rst)
        (txn_end && !busy && any_valid && !wp) |=> busy);

    // R7: an empty end of transaction leaves the block idle
    p_empty_end_r7: assert property (@(posedge clk) disable iff (rst)
        (txn_end && !busy && !any_valid) |=> !busy);

    // R6: protection drops the buffer without a window
    p_wp_discard_r6: assert property (@(posedge clk) disable iff (rst)
        (txn_end && !busy && wp) |=> (!busy && !any_valid));

    // R6: no array write while protection is asserted
    p_wp_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> (busy && !wp));

    // R8: the pointer holds during the window
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cur_addr));

    // R9: the buffer is empty once the window closes
    p_clear_after_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !any_valid);

endmodule

// File: tb/tb_page_commit_ctrl.sv
module tb_page_commit_ctrl;

    localparam int AW    = 10;
    localparam int WRC   = 24;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          addr_load, byte_load, txn_end, wp;
    logic [AW-1:0] addr_in, rd_addr, cur_addr;
    logic [7:0]    byte_in, rd_data;
    logic          busy;

    page_commit_ctrl #(.ADDR_W(AW), .WR_CYCLES(WRC)) dut (
        .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
        .byte_load(byte_load), .byte_in(byte_in), .txn_end(txn_end), .wp(wp),
        .busy(busy), .cur_addr(cur_addr), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] model [DEPTH];

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int page_addr(input int start, input int k);
        return (start & ~15) | ((start + k) & 15);
    endfunction

    task automatic set_addr(input int a);
        @(negedge clk); addr_load = 1'b1; addr_in = AW'(a);
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic burst(input int n, input int seed, input int step);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); byte_load = 1'b1; byte_in = 8'((seed + k * step) & 255);
            @(negedge clk); byte_load = 1'b0;
        end
    endtask

    task automatic model_apply(input int start, input int n, input int seed, input int step);
        for (int k = 0; k < n; k++) model[page_addr(start, k)] = 8'((seed + k * step) & 255);
    endtask

    task automatic end_txn();
        @(negedge clk); txn_end = 1'b1;
        @(negedge clk); txn_end = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk); rd_addr = AW'(a);
        @(negedge clk); v = rd_data;
    endtask

    task automatic check_page(input int base, input string tag);
        int v;
        for (int k = 0; k < 16; k++) begin
            rd((base & ~15) + k, v);
            chk(tag, v, model[(base & ~15) + k]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int v, cnt;
        rst = 1'b1; addr_load = 0; byte_load = 0; txn_end = 0; wp = 0;
        addr_in = '0; byte_in = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 busy after reset", busy, 0);
        chk("R12 cur_addr after reset", cur_addr, 0);

        // R1 R4: fill every page with full 16-byte bursts, value 7a+3
        for (int p = 0; p < DEPTH / 16; p++) begin
            set_addr(p * 16);
            burst(16, (p * 16 * 7 + 3) & 255, 7);
            model_apply(p * 16, 16, (p * 16 * 7 + 3) & 255, 7);
            end_txn();
            if (p == 0) begin
                cnt = 0;
                while (busy) begin cnt++; @(negedge clk); end
                chk("R4 busy window length", cnt, WRC);
            end
            wait_idle();
            if (p == 5) chk("R9 pointer after full page", cur_addr, 5 * 16);
        end
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, v);
            chk("R10 R1 full sweep", v, (a * 7 + 3) & 255);
        end

        // R4 R5: partial write, deferred until end of transaction
        set_addr(12'h1A5);
        burst(3, 8'hC0, 1);
        rd(12'h1A5, v);
        chk("R4 array unchanged before end", v, model[12'h1A5]);
        chk("R2 pointer after 3 bytes", cur_addr, 12'h1A8);
        model_apply(12'h1A5, 3, 8'hC0, 1);
        end_txn();
        chk("R4 busy after end", busy, 1);
        wait_idle();
        check_page(12'h1A0, "R5 partial page");

        // R2: wrap inside the page
        set_addr(12'h2FD);
        burst(5, 8'h51, 3);
        chk("R2 pointer wrapped", cur_addr, 12'h2F2);
        model_apply(12'h2FD, 5, 8'h51, 3);
        end_txn(); wait_idle();
        check_page(12'h2F0, "R2 wrapped page");
        chk("R9 pointer after wrapped commit", cur_addr, 12'h2F2);

        // R3: 20 bytes, newest per slot wins
        set_addr(12'h100);
        burst(20, 8'h10, 5);
        chk("R3 pointer after 20 bytes", cur_addr, 12'h104);
        model_apply(12'h100, 20, 8'h10, 5);
        end_txn(); wait_idle();
        check_page(12'h100, "R3 overflow page");

        // R6 R10: protected commit is discarded, reads still work
        set_addr(12'h300);
        burst(4, 8'hAA, 1);
        wp = 1'b1;
        end_txn();
        chk("R6 busy low under wp", busy, 0);
        rd(12'h301, v);
        chk("R10 read under wp", v, model[12'h301]);
        wp = 1'b0;
        end_txn();
        chk("R6 buffer discarded", busy, 0);
        check_page(12'h300, "R6 page untouched");

        // R7: empty end
        end_txn();
        chk("R7 empty end no busy", busy, 0);

        // R8: inputs ignored while busy
        set_addr(12'h040);
        burst(2, 8'h77, 2);
        model_apply(12'h040, 2, 8'h77, 2);
        end_txn();
        set_addr(12'h3F0);
        burst(2, 8'hEE, 1);
        end_txn();
        chk("R8 still busy", busy, 1);
        wait_idle();
        chk("R8 pointer untouched", cur_addr, 12'h042);
        end_txn();
        chk("R9 R8 no stale bytes", busy, 0);
        check_page(12'h040, "R8 committed page");
        check_page(12'h3F0, "R8 ignored page");

        // R11: address load ignored once bytes are buffered
        set_addr(12'h080);
        burst(1, 8'h3C, 0);
        set_addr(12'h0C0);
        burst(1, 8'h3D, 0);
        chk("R11 pointer kept", cur_addr, 12'h082);
        model[12'h080] = 8'h3C; model[12'h081] = 8'h3D;
        end_txn(); wait_idle();
        check_page(12'h080, "R11 page written");
        check_page(12'h0C0, "R11 other page untouched");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule